// File: doc/BRIEF.md
# Logarithmic Barrel Shifter and Rotator

This block moves a 32-bit word left or right by between 0 and 31 positions in a single combinational pass. The work is done in a chain of five multiplexer stages. Stage k moves the word by 2^k positions, or leaves it in place, according to bit k of the shift amount. Every stage receives the same direction and fill policy from a small decoder.

The decoder takes a two-bit operation code and, for rotation only, a direction bit. A global enable forces the whole result to zero. Typical uses are the shift unit of an integer datapath and the alignment step of a normaliser.

Top module: `log_shifter`

## Requirements
- R1: When `en` is 0, `dout` is all zeros for every value of the other inputs.
- R2: When `en` is 1 and `amount` is 0, `dout` equals `din` in every operation mode.
- R3: Operation code 2'b00 is a logical left shift: `dout` equals `din` shifted toward the MSB by `amount`, with the vacated low positions set to 0.
- R4: Operation code 2'b01 is a logical right shift: `dout` equals `din` shifted toward the LSB by `amount`, with the vacated high positions set to 0.
- R5: Operation code 2'b10 is an arithmetic right shift: the vacated high positions take the value of `din[31]`, so a negative value keeps its sign (for example, -16 shifted by 2 gives -4).
- R6: Operation code 2'b11 is a rotation. Bits that leave one end re-enter at the other end. `rot_left` = 1 rotates toward the MSB and `rot_left` = 0 rotates toward the LSB.
- R7: For operation codes 2'b00, 2'b01 and 2'b10, `rot_left` has no effect on `dout`.
- R8: Each bit k of `amount` contributes a move of exactly 2^k positions, so the total move equals the binary value of `amount` for all 32 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 32 | Word to be shifted or rotated |
| amount | input | 5 | Number of positions to move (0 to 31) |
| mode | input | 2 | Operation code: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate |
| rot_left | input | 1 | Rotate direction, used only when mode is 11: 1 toward the MSB, 0 toward the LSB |
| en | input | 1 | Output enable; 0 forces the result to zero |
| dout | output | 32 | Shifted or rotated result |

## Verification
The block holds no state, so a faulty stage or a wrong decoder output shows up at `dout` in the same evaluation. The error appears only for amount values whose corresponding bit is set, or only in the affected operation mode.

For that reason the bench sweeps all 32 amounts in every mode and direction over edge and random data. This exposes any stage with a wrong distance, a wrong fill source or an inverted direction. Checks of the rotate bit in the non-rotate modes catch a decoder that leaks direction into plain shifts.

// File: rtl/shf_pkg.sv
package shf_pkg;
  // operation codes seen at the mode port
  typedef enum logic [1:0] {
    OP_SLL = 2'b00,
    OP_SRL = 2'b01,
    OP_SRA = 2'b10,
    OP_ROT = 2'b11
  } shf_op_e;

  // source for positions vacated by a stage
  typedef enum logic [1:0] {
    FILL_ZERO = 2'b00,
    FILL_SIGN = 2'b01,
    FILL_WRAP = 2'b10
  } shf_fill_e;
endpackage

// File: rtl/shf_decode.sv
module shf_decode
  import shf_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       rot_left,
  output logic       go_left,
  output shf_fill_e  fill
);
  always_comb begin
    go_left = 1'b0;
    fill    = FILL_ZERO;
    unique case (shf_op_e'(mode))
      OP_SLL: begin go_left = 1'b1;     fill = FILL_ZERO; end
      OP_SRL: begin go_left = 1'b0;     fill = FILL_ZERO; end
      OP_SRA: begin go_left = 1'b0;     fill = FILL_SIGN; end
      OP_ROT: begin go_left = rot_left; fill = FILL_WRAP; end
      default: begin go_left = 1'b0;    fill = FILL_ZERO; end
    endcase
  end
endmodule

// File: rtl/shf_stage.sv
module shf_stage
  import shf_pkg::*;
#(
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  logic [W-1:0] din,
  input  logic         step,
  input  logic         go_left,
  input  shf_fill_e    fill,
  output logic [W-1:0] dout
);
  logic [W-1:0] left_val;
  logic [W-1:0] right_val;
  logic         wrap;
  logic         sign_fill;

  assign wrap      = (fill == FILL_WRAP);
  assign sign_fill = (fill == FILL_SIGN) & din[W-1];

  for (genvar i = 0; i < W; i++) begin : g_bit
    // move toward MSB: bit i comes from i-DIST
    if (i >= DIST) begin : g_l_in
      assign left_val[i] = din[i-DIST];
    end else begin : g_l_fill
      assign left_val[i] = wrap & din[W-DIST+i];
    end
    // move toward LSB: bit i comes from i+DIST
    if (i + DIST < W) begin : g_r_in
      assign right_val[i] = din[i+DIST];
    end else begin : g_r_fill
      assign right_val[i] = wrap ? din[i+DIST-W] : sign_fill;
    end
  end

  always_comb begin
    if (!step)        dout = din;
    else if (go_left) dout = left_val;
    else              dout = right_val;
  end
endmodule

// File: rtl/log_shifter.sv
module log_shifter
  import shf_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amount,
  input  logic [1:0]    mode,
  input  logic          rot_left,
  input  logic          en,
  output logic [W-1:0]  dout
);
  localparam int NSTG = AW;

  logic         go_left;
  shf_fill_e    fill;
  logic [W-1:0] lvl [0:NSTG];

  shf_decode u_dec (
    .mode     (mode),
    .rot_left (rot_left),
    .go_left  (go_left),
    .fill     (fill)
  );

  assign lvl[0] = din;

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    shf_stage #(.W(W), .DIST(1 << k)) u_stg (
      .din     (lvl[k]),
      .step    (amount[k]),
      .go_left (go_left),
      .fill    (fill),
      .dout    (lvl[k+1])
    );
  end

  assign dout = en ? lvl[NSTG] : '0;

  // port-level properties of the shifter
  always_comb begin
    if (en === 1'b0)
      assert_zero_when_off_R1: assert (dout == '0);
    if (en === 1'b1 && amount == '0)
      assert_pass_at_zero_R2: assert (dout == din);
    if (en === 1'b1 && mode == OP_SLL && amount != '0)
      assert_lsb_cleared_R3: assert (dout[0] == 1'b0);
    if (en === 1'b1 && mode == OP_SRL && amount != '0)
      assert_msb_cleared_R4: assert (dout[W-1] == 1'b0);
    if (en === 1'b1 && mode == OP_SRA)
      assert_sign_kept_R5: assert (dout[W-1] == din[W-1]);
    if (en === 1'b1 && mode == OP_ROT)
      assert_bits_conserved_R6: assert ($countones(dout) == $countones(din));
  end
endmodule

// File: tb/sim_log_shifter.sv
module sim_log_shifter;
  logic        clk;
  logic [31:0] din;
  logic [4:0]  amount;
  logic [1:0]  mode;
  logic        rot_left;
  logic        en;
  logic [31:0] dout;

  int n_vec  = 0;
  int n_bad  = 0;
  int cycles = 0;
  bit done   = 0;

  log_shifter u0 (
    .din(din), .amount(amount), .mode(mode),
    .rot_left(rot_left), .en(en), .dout(dout)
  );

  initial clk = 0;
  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] model(input logic [31:0] d, input int a,
                                         input logic [1:0] m, input logic rl,
                                         input logic e);
    logic [31:0] r;
    if (!e) return 32'h0;
    case (m)
      2'b00: r = d << a;
      2'b01: r = d >> a;
      2'b10: r = $unsigned($signed(d) >>> a);
      default: begin
        if (a == 0)  r = d;
        else if (rl) r = (d << a) | (d >> (32 - a));
        else         r = (d >> a) | (d << (32 - a));
      end
    endcase
    return r;
  endfunction

  task automatic apply(input logic [31:0] d, input int a, input logic [1:0] m,
                       input logic rl, input logic e, input string req);
    logic [31:0] exp;
    @(posedge clk);
    #1;
    din = d; amount = a[4:0]; mode = m; rot_left = rl; en = e;
    exp = model(d, a, m, rl, e);
    @(negedge clk);
    n_vec++;
    if (dout !== exp) begin
      n_bad++;
      $display("FAIL %s: din=%h amt=%0d mode=%b dir=%b en=%b actual=%h expected=%h",
               req, d, a, m, rl, e, dout, exp);
    end
  endtask

  function automatic string tag(input logic [1:0] m, input int a);
    if (a == 0) return "R2";
    case (m)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  logic [31:0] pats [0:11];

  initial begin
    din = 0; amount = 0; mode = 0; rot_left = 0; en = 0;
    pats[0] = 32'h0000_0001; pats[1] = 32'h8000_0000;
    pats[2] = 32'hFFFF_FFFF; pats[3] = 32'h0000_0000;
    pats[4] = 32'hC800_0019; pats[5] = 32'h5555_AAAA;
    for (int i = 6; i < 12; i++) pats[i] = $urandom;

    // R1: disabled output, several inputs
    for (int i = 0; i < 12; i++)
      apply(pats[i], i * 3 % 32, i[1:0], i[0], 1'b0, "R1");

    // R8 with R2..R6: every amount, every mode, both directions
    for (int p = 0; p < 12; p++)
      for (int m = 0; m < 4; m++)
        for (int dr = 0; dr < 2; dr++)
          for (int a = 0; a < 32; a++)
            apply(pats[p], a, m[1:0], dr[0], 1'b1, tag(m[1:0], a));

    // R5: negative value keeps sign, -16 by 2 -> -4
    apply(32'hFFFF_FFF0, 2, 2'b10, 1'b0, 1'b1, "R5");
    // R6: rotate examples in both directions
    apply(32'hC800_0001, 2, 2'b11, 1'b0, 1'b1, "R6");
    apply(32'hC800_0001, 2, 2'b11, 1'b1, 1'b1, "R6");

    // R7: direction bit ignored for plain shifts (expected from model with rl=0)
    for (int m = 0; m < 3; m++)
      for (int a = 1; a < 32; a += 5) begin
        logic [31:0] exp0;
        exp0 = model(pats[4], a, m[1:0], 1'b0, 1'b1);
        @(posedge clk); #1;
        din = pats[4]; amount = a[4:0]; mode = m[1:0]; rot_left = 1'b1; en = 1'b1;
        @(negedge clk);
        n_vec++;
        if (dout !== exp0) begin
          n_bad++;
          $display("FAIL R7: mode=%b amt=%0d actual=%h expected=%h", m[1:0], a, dout, exp0);
        end
      end

    // R8: single-bit amounts on a lone bit
    for (int k = 0; k < 5; k++)
      apply(32'h0000_0001, 1 << k, 2'b00, 1'b0, 1'b1, "R8");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule